// File: doc/BRIEF.md
# Write Leveling Training Sequencer

This block runs write-leveling training for one byte lane of a DDR4-style memory interface. When started, it sends the mode-register command that puts the memory into leveling mode and raises the termination enable. It then waits until both the mode-register delay and the termination settling time have passed. After that it fires one strobe pulse per delay tap, counting the tap upward from zero. For each pulse it samples the level the memory returns on the data lines, which is the clock level the memory saw at the strobe's rising edge.

The sweep stops at the first tap whose feedback reads high after a tap that read low. The sequencer then leaves leveling mode in a fixed order: it stops the strobe, drops termination, waits for termination to switch off, sends the mode-register command that disables leveling, and waits the mode-register delay. Only then does it report the tap found and a fail flag. Every timing value is a cycle-count input. The settling time used is chosen by a DLL-enable input.

Top module: `wl_train_seq`

## Requirements
- R1: After reset, cmd_o is 0 (deselect), odt_o, dqs_en_o, busy_o, done_o, fail_o are 0 and tap_o and result_tap_o are 0.
- R2: A start pulse while idle makes cmd_o show code 1 (enter leveling) for exactly one cycle, with odt_o and busy_o high from that same cycle. Between that cycle and the exit command only code 0 appears.
- R3: The first strobe rise (dqs_en_o going high) comes exactly W cycles after the entry command cycle. W = max(t_wlmrd, t_mod + S + 1), where S is t_odt_dll when dll_en is 1 and t_aonas when it is 0, with dll_en sampled at start.
- R4: Each strobe pulse is high for exactly t_dqsh cycles. The next rise follows max(t_dqsl, t_wlo) + 1 low cycles later. tap_o gives the pulse's tap, which is 0 for the first pulse and rises by 1 per pulse.
- R5: Feedback is sampled in the last low cycle of each pulse and reduced by majority: it reads 1 only when more than half of the DQ_W bits are 1. An even split reads 0.
- R6: The sweep ends at the first tap whose feedback reads 1 while the previous tap read 0. That tap is reported on result_tap_o with fail_o 0, including when it is the highest tap.
- R7: Exit order is fixed. odt_o falls in the cycle after the final sample. cmd_o shows code 2 (leave leveling) for one cycle, S cycles after odt_o fell. done_o pulses t_mod cycles after that command.
- R8: Data-line values after the final sample have no effect on the reported result, the exit timing or the outputs.
- R9: If no low-to-high change occurs by the highest tap (2^TAP_W - 1), the full exit sequence still runs, then fail_o is 1 and result_tap_o is the highest tap.
- R10: done_o is a one-cycle pulse with busy_o already low. A start pulse while busy_o is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin training (single-cycle pulse) |
| dll_en_i | input | 1 | Selects DLL-on termination settling time |
| t_wlmrd_i | input | CNT_W | Entry command to first strobe, cycles |
| t_mod_i | input | CNT_W | Mode-register command delay, cycles |
| t_odt_dll_i | input | CNT_W | Termination settling with DLL on, cycles |
| t_aonas_i | input | CNT_W | Termination settling with DLL off, cycles |
| t_dqsh_i | input | CNT_W | Strobe high width, cycles |
| t_dqsl_i | input | CNT_W | Strobe low width, cycles |
| t_wlo_i | input | CNT_W | Feedback delay after strobe rise, cycles |
| dq_fb_i | input | DQ_W | Leveling feedback from the data lines |
| cmd_o | output | 2 | 0 deselect, 1 enter leveling, 2 leave leveling |
| odt_o | output | 1 | Termination enable |
| dqs_en_o | output | 1 | Strobe pulse enable |
| tap_o | output | TAP_W | Delay tap for the strobe |
| busy_o | output | 1 | Training in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_tap_o | output | TAP_W | Tap found |
| fail_o | output | 1 | No transition found |

## Verification
Two events can land on the same sample cycle: the low-to-high detection and the end of the sweep at the highest tap. The bench sets up the feedback so that the only change happens exactly at the top tap. The scoreboard then expects a success report with that tap, not a failure, and the same exit timing as any other finish. A second case sends a start pulse while a sweep is running and checks that no extra entry command or timing shift appears.

// File: rtl/wl_pkg.sv
package wl_pkg;
  typedef enum logic [1:0] {
    CMD_DES    = 2'd0,
    CMD_WL_ON  = 2'd1,
    CMD_WL_OFF = 2'd2
  } wl_cmd_e;

  typedef enum logic [2:0] {
    S_IDLE, S_ENTRY, S_HIGH, S_LOW, S_GAP, S_ODT_OFF, S_MOD_WAIT
  } wl_state_e;
endpackage

// File: rtl/wl_timer.sv
module wl_timer #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] len,
  output logic         expired
);
  logic [W-1:0] cnt;

  // A load of len keeps the owning state for len cycles (minimum 1).
  always_ff @(posedge clk) begin
    if (rst)               cnt <= '0;
    else if (load)         cnt <= (len == '0) ? '0 : len - 1'b1;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/wl_vote.sv
module wl_vote #(
  parameter int N = 4
) (
  input  logic [N-1:0] bits,
  output logic         maj
);
  localparam int CW = $clog2(N + 1);
  logic [CW-1:0] ones;

  always_comb begin
    ones = '0;
    for (int i = 0; i < N; i++) ones = ones + CW'(bits[i]);
  end

  assign maj = (ones > CW'(N / 2));
endmodule

// File: rtl/wl_train_seq.sv
module wl_train_seq
  import wl_pkg::*;
#(
  parameter int DQ_W  = 4,
  parameter int TAP_W = 6,
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             dll_en_i,
  input  logic [CNT_W-1:0] t_wlmrd_i,
  input  logic [CNT_W-1:0] t_mod_i,
  input  logic [CNT_W-1:0] t_odt_dll_i,
  input  logic [CNT_W-1:0] t_aonas_i,
  input  logic [CNT_W-1:0] t_dqsh_i,
  input  logic [CNT_W-1:0] t_dqsl_i,
  input  logic [CNT_W-1:0] t_wlo_i,
  input  logic [DQ_W-1:0]  dq_fb_i,
  output logic [1:0]       cmd_o,
  output logic             odt_o,
  output logic             dqs_en_o,
  output logic [TAP_W-1:0] tap_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [TAP_W-1:0] result_tap_o,
  output logic             fail_o
);
  localparam int TW = CNT_W + 2;
  localparam logic [TAP_W-1:0] TAP_MAX = '1;

  wl_state_e       state;
  logic            dll_q, prev_zero, found_q;
  logic            vote, tmr_load, tmr_done, found_now, sweep_end;
  logic [TW-1:0]   tmr_len, settle_len, entry_len, hi_len, lo_len, mod_len;
  logic [TW-1:0]   wlmrd_len, odt_need;

  function automatic logic [TW-1:0] lenf(input logic [CNT_W-1:0] v);
    return (v == '0) ? TW'(1) : TW'(v);
  endfunction

  // Length of each timed phase, in cycles.
  always_comb begin
    settle_len = ((state == S_IDLE) ? dll_en_i : dll_q) ? lenf(t_odt_dll_i) : lenf(t_aonas_i);
    mod_len    = lenf(t_mod_i);
    wlmrd_len  = lenf(t_wlmrd_i);
    odt_need   = mod_len + settle_len + TW'(1);
    entry_len  = (wlmrd_len > odt_need) ? wlmrd_len : odt_need;
    hi_len     = lenf(t_dqsh_i);
    lo_len     = (lenf(t_dqsl_i) > lenf(t_wlo_i)) ? lenf(t_dqsl_i) : lenf(t_wlo_i);
  end

  wl_vote #(.N(DQ_W)) u_vote (.bits(dq_fb_i), .maj(vote));

  assign found_now = prev_zero & vote;
  assign sweep_end = found_now | (tap_o == TAP_MAX);

  always_comb begin
    tmr_load = 1'b0;
    tmr_len  = TW'(1);
    unique case (state)
      S_IDLE:     if (start_i)  begin tmr_load = 1'b1; tmr_len = entry_len;  end
      S_ENTRY:    if (tmr_done) begin tmr_load = 1'b1; tmr_len = hi_len;     end
      S_HIGH:     if (tmr_done) begin tmr_load = 1'b1; tmr_len = lo_len;     end
      S_LOW:      if (tmr_done && sweep_end) begin tmr_load = 1'b1; tmr_len = settle_len; end
      S_GAP:      begin tmr_load = 1'b1; tmr_len = hi_len; end
      S_ODT_OFF:  if (tmr_done) begin tmr_load = 1'b1; tmr_len = mod_len;    end
      default:    ;
    endcase
  end

  wl_timer #(.W(TW)) u_timer (
    .clk(clk), .rst(rst), .load(tmr_load), .len(tmr_len), .expired(tmr_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= S_IDLE;
      cmd_o        <= CMD_DES;
      odt_o        <= 1'b0;
      dqs_en_o     <= 1'b0;
      tap_o        <= '0;
      busy_o       <= 1'b0;
      done_o       <= 1'b0;
      result_tap_o <= '0;
      fail_o       <= 1'b0;
      dll_q        <= 1'b0;
      prev_zero    <= 1'b0;
      found_q      <= 1'b0;
    end else begin
      cmd_o  <= CMD_DES;
      done_o <= 1'b0;
      unique case (state)
        S_IDLE: if (start_i) begin
          state     <= S_ENTRY;
          cmd_o     <= CMD_WL_ON;
          odt_o     <= 1'b1;
          busy_o    <= 1'b1;
          tap_o     <= '0;
          prev_zero <= 1'b0;
          found_q   <= 1'b0;
          dll_q     <= dll_en_i;
        end
        S_ENTRY: if (tmr_done) begin
          state    <= S_HIGH;
          dqs_en_o <= 1'b1;
        end
        S_HIGH: if (tmr_done) begin
          state    <= S_LOW;
          dqs_en_o <= 1'b0;
        end
        S_LOW: if (tmr_done) begin
          if (sweep_end) begin
            state   <= S_ODT_OFF;
            odt_o   <= 1'b0;
            found_q <= found_now;
          end else begin
            state     <= S_GAP;
            tap_o     <= tap_o + 1'b1;
            prev_zero <= ~vote;
          end
        end
        S_GAP: begin
          state    <= S_HIGH;
          dqs_en_o <= 1'b1;
        end
        S_ODT_OFF: if (tmr_done) begin
          state <= S_MOD_WAIT;
          cmd_o <= CMD_WL_OFF;
        end
        S_MOD_WAIT: if (tmr_done) begin
          state        <= S_IDLE;
          done_o       <= 1'b1;
          busy_o       <= 1'b0;
          result_tap_o <= tap_o;
          fail_o       <= ~found_q;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/wl_train_seq_chk.sv
module wl_train_seq_chk #(
  parameter int CNT_W = 10
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       cmd,
  input logic             odt,
  input logic             dqs_en,
  input logic             busy,
  input logic             done,
  input logic [CNT_W-1:0] t_wlmrd,
  input logic [CNT_W-1:0] t_dqsh
);
  localparam int TW = CNT_W + 2;
  logic [TW-1:0] since_entry, hi_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      since_entry <= '0;
      hi_run      <= '0;
    end else begin
      if (cmd == 2'd1)              since_entry <= TW'(1);
      else if (since_entry != '1)   since_entry <= since_entry + 1'b1;
      hi_run <= dqs_en ? hi_run + 1'b1 : '0;
    end
  end

  // R2: entry command comes with termination on and from an idle state
  assert_entry_odt_R2: assert property (@(posedge clk) disable iff (rst)
    (cmd == 2'd1) |-> (odt && busy && !$past(busy)));

  // R3: no strobe edge before the mode-register delay from entry
  assert_wlmrd_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(dqs_en) |-> (since_entry >= TW'(t_wlmrd)));

  // R4: strobe only while termination is on
  assert_strobe_odt_R4: assert property (@(posedge clk) disable iff (rst)
    dqs_en |-> (odt && busy));

  // R4: strobe high width
  assert_high_width_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(dqs_en) |-> (hi_run == TW'(t_dqsh)));

  // R7: leave command only with strobe stopped and termination off
  assert_exit_order_R7: assert property (@(posedge clk) disable iff (rst)
    (cmd == 2'd2) |-> (!odt && !dqs_en && busy));

  // R10: done is a single pulse with busy low
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy ##1 !done);
endmodule

bind wl_train_seq wl_train_seq_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .cmd(cmd_o), .odt(odt_o), .dqs_en(dqs_en_o),
  .busy(busy_o), .done(done_o), .t_wlmrd(t_wlmrd_i), .t_dqsh(t_dqsh_i)
);

// File: tb/sim_wl_train_seq.sv
module sim_wl_train_seq;
  localparam int DQ_W  = 4;
  localparam int TAP_W = 6;
  localparam int CNT_W = 10;
  localparam int TMAX  = (1 << TAP_W) - 1;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic             rst, start, dll_en;
  logic [CNT_W-1:0] t_wlmrd, t_mod, t_odtd, t_aonas, t_dqsh, t_dqsl, t_wlo;
  logic [DQ_W-1:0]  dq;
  logic [1:0]       cmd;
  logic             odt, dqs_en, busy, done, fail;
  logic [TAP_W-1:0] tap, res_tap;

  wl_train_seq #(.DQ_W(DQ_W), .TAP_W(TAP_W), .CNT_W(CNT_W)) u0 (
    .clk(clk), .rst(rst), .start_i(start), .dll_en_i(dll_en),
    .t_wlmrd_i(t_wlmrd), .t_mod_i(t_mod), .t_odt_dll_i(t_odtd), .t_aonas_i(t_aonas),
    .t_dqsh_i(t_dqsh), .t_dqsl_i(t_dqsl), .t_wlo_i(t_wlo), .dq_fb_i(dq),
    .cmd_o(cmd), .odt_o(odt), .dqs_en_o(dqs_en), .tap_o(tap), .busy_o(busy),
    .done_o(done), .result_tap_o(res_tap), .fail_o(fail)
  );

  typedef struct { int kind; int rel; int val; string req; } ev_t;
  ev_t expq[$];
  int checks = 0, failures = 0, cyc = 0, base = 0, done_cnt = 0;
  int pa = 0, pb = 0;
  logic [DQ_W-1:0] lo_w = '0, hi_w = '1;
  bit pdqs = 0, podt = 0;

  function automatic bit fb(int t);
    return (t < pa) ? 1'b1 : ((t < pb) ? 1'b0 : 1'b1);
  endfunction

  function automatic bit maj(logic [DQ_W-1:0] w);
    int n = 0;
    for (int i = 0; i < DQ_W; i++) n += w[i];
    return n > DQ_W / 2;
  endfunction

  task automatic report(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic log_ev(int kind, int val);
    ev_t e;
    int rel = cyc - base;
    if (expq.size() == 0) begin
      checks++; failures++;
      $display("FAIL R2/R10 unexpected event kind=%0d actual=%0d expected=none", kind, rel);
      return;
    end
    e = expq.pop_front();
    report(e.req, "event kind", kind, e.kind);
    report(e.req, "event cycle", rel, e.rel);
    report(e.req, "event value", val, e.val);
  endtask

  // Responder: feedback follows the tap while termination is on, junk otherwise (R8)
  initial begin
    dq = '0;
    forever begin
      @(negedge clk);
      if (odt) dq = fb(int'(tap)) ? hi_w : lo_w;
      else     dq = cyc[0] ? '1 : '0;
    end
  end

  // Monitor
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (!rst) begin
        if (cmd == 2'd1) begin base = cyc; log_ev(1, 0); end
        if (dqs_en && !pdqs) log_ev(2, int'(tap));
        if (!odt && podt) log_ev(3, 0);
        if (cmd == 2'd2) log_ev(4, 0);
        if (cmd == 2'd3) report("R2", "illegal command", 3, 0);
        if (done) begin
          report("R10", "busy in done cycle", int'(busy), 0);
          log_ev(5, int'({fail, res_tap}));
          done_cnt++;
        end
      end
      pdqs = dqs_en;
      podt = odt;
    end
  end

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  task automatic run_case(string req, bit dll, int wlmrd, int tmod, int odtd, int aonas,
                          int h, int l, int wlo, int a, int b,
                          logic [DQ_W-1:0] lw, logic [DQ_W-1:0] hw, bit inject);
    int s, w, lm, p, n, res, target, guard;
    bit fl, prevz, v;
    @(negedge clk);
    dll_en = dll; t_wlmrd = CNT_W'(wlmrd); t_mod = CNT_W'(tmod);
    t_odtd = CNT_W'(odtd); t_aonas = CNT_W'(aonas);
    t_dqsh = CNT_W'(h); t_dqsl = CNT_W'(l); t_wlo = CNT_W'(wlo);
    pa = a; pb = b; lo_w = lw; hi_w = hw;
    s  = dll ? odtd : aonas;
    w  = (wlmrd > tmod + s + 1) ? wlmrd : tmod + s + 1;
    lm = (l > wlo) ? l : wlo;
    p  = h + lm + 1;
    prevz = 0; fl = 1; res = TMAX;
    for (int t = 0; t <= TMAX; t++) begin
      v = fb(t) ? maj(hw) : maj(lw);
      if (prevz && v) begin res = t; fl = 0; break; end
      prevz = !v;
    end
    n = res + 1;
    expq.push_back('{1, 0, 0, "R2"});
    for (int k = 0; k < n; k++)
      expq.push_back('{2, w + k * p, k, (k == 0) ? "R3" : "R4"});
    expq.push_back('{3, w + (n - 1) * p + h + lm, 0, "R7"});
    expq.push_back('{4, w + (n - 1) * p + h + lm + s, 0, "R7"});
    expq.push_back('{5, w + (n - 1) * p + h + lm + s + tmod, int'({fl, 6'(res)}), req});
    target = done_cnt + 1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (inject) begin
      repeat (7) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    guard = 0;
    while (done_cnt < target) begin
      @(negedge clk);
      guard++;
      if (guard > 20000) begin
        checks++; failures++;
        $display("FAIL %s watchdog actual=%0d expected=%0d", req, done_cnt, target);
        finish_run();
      end
    end
    report(req, "leftover expected events", expq.size(), 0);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    rst = 1'b1; start = 1'b0; dll_en = 1'b0;
    t_wlmrd = '0; t_mod = '0; t_odtd = '0; t_aonas = '0;
    t_dqsh = '0; t_dqsl = '0; t_wlo = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    report("R1", "cmd", int'(cmd), 0);
    report("R1", "odt", int'(odt), 0);
    report("R1", "dqs_en", int'(dqs_en), 0);
    report("R1", "busy", int'(busy), 0);
    report("R1", "done/fail", int'({done, fail}), 0);
    report("R1", "taps", int'({tap, res_tap}), 0);

    // R6 basic sweep, DLL on, settling dominates entry wait
    run_case("R6", 1, 5, 4, 3, 2, 2, 2, 3, 0, 5, 4'b0000, 4'b1111, 0);
    // R5 majority: split reads 0, three of four reads 1; DLL off, wlmrd dominates
    run_case("R5", 0, 20, 3, 9, 2, 1, 4, 2, 0, 12, 4'b0011, 4'b1011, 0);
    // R6 feedback starts high, goes low, then high again
    run_case("R6", 1, 3, 2, 4, 7, 3, 1, 2, 3, 10, 4'b0000, 4'b1111, 0);
    // R9 feedback always high: no transition, full exit then fail
    run_case("R9", 0, 2, 2, 1, 3, 1, 1, 1, TMAX + 1, TMAX + 1, 4'b0000, 4'b1111, 0);
    // R6 transition exactly at the highest tap: success, not fail
    run_case("R6", 1, 4, 3, 2, 2, 1, 2, 2, 0, TMAX, 4'b0000, 4'b1111, 0);
    // R10 start while busy is ignored
    run_case("R10", 1, 6, 2, 2, 2, 2, 2, 2, 0, 4, 4'b0000, 4'b1111, 1);

    // R8 junk on data lines after the run changes nothing
    repeat (20) @(negedge clk);
    report("R8", "result held", int'({fail, res_tap}), 4);
    report("R8", "idle outputs", int'({cmd, odt, dqs_en, busy}), 0);
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; failures++;
    $display("FAIL global watchdog actual=%0d expected=%0d", 150000, 0);
    finish_run();
  end
endmodule